// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the IF rising edges that arrive while a gate window is open. The window is timed by a 75 kHz reference tick, and a 2-bit select picks one of four gate lengths: 4, 8, 16 or 32 ms. With a 20-bit count, an input of up to 12 MHz over the longest gate (384000 edges) fits with room to spare. If the count does reach all ones, it saturates there and an overflow flag is raised.

A single-cycle start pulse opens the window. When the last reference tick of the window arrives, the count freezes and a done flag goes high. A controller can then read the frozen count serially, most significant bit first, by pulsing a shift enable once per bit. The done flag clears when the last bit has been shifted or when the next measurement starts.

The IF input and the reference are both delivered as single-cycle enables in the system clock domain. Synchronising and shaping the analogue signals happen upstream of this block.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, busy, done, overflow and serial_out are 0 and the count is 0.
- R2: A start pulse while busy is 0 sets busy on the next clock edge, clears count and overflow, and clears done.
- R3: The gate closes on the Nth reference tick seen while busy, where N = 300, 600, 1200 or 2400 for gate select codes 00, 01, 10 and 11. The gate select is sampled only in the start cycle.
- R4: An IF edge enable is counted in every cycle in which busy is 1, including the cycle that carries the closing reference tick. An edge in the start cycle is not counted.
- R5: In the cycle after the closing tick, busy is 0 and done is 1. The count then holds its value until the next accepted start.
- R6: A start pulse while busy is 1 has no effect on the count, on the gate length or on when the gate closes.
- R7: The count saturates at all ones. An edge that arrives while the count is at all ones sets overflow, and overflow stays set until the next accepted start.
- R8: While done is 1, serial_out presents the count MSB first. Each shift_en pulse advances one bit. The pulse that consumes the LSB clears done, and serial_out is 0 whenever done is 0.
- R9: shift_en while done is 0 has no effect on serial_out, done or the count.
- R10: Without shift pulses, done stays 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse at the 75 kHz reference rate |
| if_edge | input | 1 | One-cycle pulse per IF rising edge |
| start | input | 1 | Begins a measurement when idle |
| gate_sel | input | 2 | Gate length select (00..11 → 300..2400 ticks) |
| shift_en | input | 1 | Advances the serial readout by one bit |
| count | output | CNT_W | Running and then frozen edge count |
| overflow | output | 1 | Count saturated during this measurement |
| busy | output | 1 | Gate window open |
| done | output | 1 | Result ready for readout |
| serial_out | output | 1 | Current readout bit, MSB first |

## Verification
Two functions can fall in the same cycle: the reference tick that closes the gate and an IF edge. The bench provokes this by placing edges on exactly the tick cycles, so an edge lands on the closing tick. It then compares the frozen count with a count taken from its own stimulus, which must include that last edge.

A second overlap is an edge in the start cycle itself. The bench drives one there and checks that it is excluded from the count.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef struct packed {
        logic        busy;
        logic [1:0]  sel;
        logic [11:0] ticks;
    } gate_state_t;
endpackage

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
    parameter int GATE_BASE = 300,
    parameter int TICK_W    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       start,
    input  logic [1:0] gate_sel,
    output logic       busy,
    output logic       launch,
    output logic       close
);
    import ifc_pkg::*;

    gate_state_t st_d, st_q;
    logic [TICK_W-1:0] gate_len;

    always_comb begin
        gate_len = TICK_W'(GATE_BASE) << st_q.sel;
        launch   = start && !st_q.busy;
        close    = st_q.busy && ref_tick && (st_q.ticks[TICK_W-1:0] == gate_len - 1'b1);
        st_d     = st_q;
        if (launch) begin
            st_d.busy  = 1'b1;
            st_d.sel   = gate_sel;
            st_d.ticks = '0;
        end else if (close) begin
            st_d.busy  = 1'b0;
        end else if (st_q.busy && ref_tick) begin
            st_d.ticks = st_q.ticks + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/ifc_edge_counter.sv
module ifc_edge_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (count_en) begin
            if (&st_q.cnt) st_d.ovf = 1'b1;
            else           st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign overflow = st_q.ovf;
endmodule

// File: rtl/ifc_serializer.sv
module ifc_serializer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             close,
    input  logic [CNT_W-1:0] result,
    input  logic             shift_en,
    output logic             done,
    output logic             serial_out
);
    localparam int IDX_W = $clog2(CNT_W);

    typedef struct packed {
        logic             done;
        logic [CNT_W-1:0] sh;
        logic [IDX_W-1:0] idx;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.done = 1'b0;
        end else if (close) begin
            st_d.done = 1'b1;
            st_d.sh   = result;
            st_d.idx  = '0;
        end else if (st_q.done && shift_en) begin
            st_d.sh  = st_q.sh << 1;
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == IDX_W'(CNT_W - 1)) st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done       = st_q.done;
    assign serial_out = st_q.done & st_q.sh[CNT_W-1];
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter #(
    parameter int CNT_W     = 20,
    parameter int GATE_BASE = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             if_edge,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    input  logic             shift_en,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             busy,
    output logic             done,
    output logic             serial_out
);
    localparam int TICK_W = 12;

    logic launch, close;
    logic [CNT_W-1:0] cnt_next;

    ifc_gate_timer #(.GATE_BASE(GATE_BASE), .TICK_W(TICK_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .start(start),
        .gate_sel(gate_sel), .busy(busy), .launch(launch), .close(close)
    );

    ifc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(launch), .count_en(busy && if_edge),
        .count(count), .overflow(overflow)
    );

    // the closing cycle's edge must be part of the latched result
    assign cnt_next = (if_edge && !(&count)) ? count + 1'b1 : count;

    ifc_serializer #(.CNT_W(CNT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .launch(launch), .close(close),
        .result(cnt_next), .shift_en(shift_en), .done(done),
        .serial_out(serial_out)
    );
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             overflow,
    input logic             serial_out,
    input logic [CNT_W-1:0] count
);
    a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && count == '0 && !overflow));

    a_r5_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(count));

    a_r7_overflow_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&count));

    a_r4_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count >= $past(count)));

    a_r8_serial_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !serial_out);
endmodule

bind if_freq_counter ifc_checker #(.CNT_W(CNT_W)) u_ifc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .overflow(overflow), .serial_out(serial_out), .count(count)
);

// File: tb/if_freq_counter_bench.sv
`timescale 1ns/1ps
module if_freq_counter_bench;
    localparam int BW = 12;

    logic clk = 0, rst_n = 0;
    logic ref_tick = 0, if_edge = 0, start = 0, shift_en = 0;
    logic [1:0] gate_sel = 0;
    logic [BW-1:0] count;
    logic overflow, busy, done, serial_out;
    int checks = 0, errors = 0;

    if_freq_counter #(.CNT_W(BW)) u_if_freq_counter (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .if_edge(if_edge),
        .start(start), .gate_sel(gate_sel), .shift_en(shift_en),
        .count(count), .overflow(overflow), .busy(busy), .done(done),
        .serial_out(serial_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one measurement; returns the count expected from the stimulus
    task automatic measure(input logic [1:0] sel, input int tp, input int ep,
                           input int eoff, input bit mid_start, input string req,
                           output int exp);
        int len = 300 << sel;
        int ticks = 0;
        exp = 0;
        @(negedge clk);
        start = 1; gate_sel = sel; if_edge = 1;   // R4: start-cycle edge ignored
        @(negedge clk);
        start = 0; if_edge = 0;
        chk({req, " R2 busy after start"}, busy, 1);
        chk({req, " R2 count cleared"}, count, 0);
        for (int c = 0; ticks < len; c++) begin
            ref_tick = (c % tp == tp - 1);
            if_edge  = (ep > 0) && (c % ep == eoff);
            if (if_edge && exp < (1 << BW) - 1) exp++;
            if (ref_tick) ticks++;
            start = mid_start && (c == 5);
            if (mid_start && c == 5) gate_sel = ~sel;  // R6: must not alter length
            @(negedge clk);
        end
        ref_tick = 0; if_edge = 0; start = 0; gate_sel = sel;
        chk({req, " R5 busy low after gate"}, busy, 0);
        chk({req, " R5 done high after gate"}, done, 1);
        chk({req, " R3/R4 count"}, count, exp);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 serial_out", serial_out, 0);
        chk("R1 count", count, 0);
    endtask

    task automatic t_gate_lengths();
        int e;
        for (int s = 0; s < 4; s++) begin
            measure(2'(s), 2, 3, 1, 0, "R3 gate length", e);
        end
    endtask

    task automatic t_close_edge();
        int e;
        // edges on tick cycles only: last edge coincides with closing tick (R4)
        measure(2'b00, 4, 4, 3, 0, "R4 edge on closing tick", e);
        chk("R4 edges equal ticks", count, 300);
    endtask

    task automatic t_busy_start();
        int e;
        measure(2'b01, 2, 5, 0, 1, "R6 start while busy", e);
        chk("R6 gate length unchanged", count, 240);
    endtask

    task automatic t_readout();
        int e;
        measure(2'b00, 3, 7, 2, 0, "R8 pre-readout", e);
        for (int i = BW - 1; i >= 0; i--) begin
            chk("R8 serial bit", serial_out, (e >> i) & 1);
            chk("R8 done during readout", done, 1);
            shift_en = 1;
            @(negedge clk);
        end
        shift_en = 0;
        chk("R8 done cleared after LSB", done, 0);
        chk("R8 serial_out low after readout", serial_out, 0);
        chk("R8 count held", count, e);
    endtask

    task automatic t_shift_idle();
        int held = count;
        for (int i = 0; i < 4; i++) begin
            shift_en = 1;
            @(negedge clk);
            chk("R9 serial_out idle", serial_out, 0);
            chk("R9 done idle", done, 0);
        end
        shift_en = 0;
        chk("R9 count unchanged", count, held);
    endtask

    task automatic t_done_hold();
        int e;
        measure(2'b00, 2, 9, 4, 0, "R10 measure", e);
        repeat (50) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R5 count held idle", count, e);
        start = 1; gate_sel = 0;
        @(negedge clk);
        start = 0;
        chk("R10 done cleared by start", done, 0);
        chk("R2 count cleared by restart", count, 0);
        for (int i = 0; i < 2000 && busy; i++) begin
            ref_tick = (i % 2 == 1);
            @(negedge clk);
        end
        ref_tick = 0;
    endtask

    task automatic t_overflow();
        int e;
        measure(2'b11, 2, 1, 0, 0, "R7 saturate", e);
        chk("R7 count at all ones", count, (1 << BW) - 1);
        chk("R7 overflow set", overflow, 1);
        start = 1;
        @(negedge clk);
        start = 0;
        chk("R7 overflow cleared by start", overflow, 0);
        for (int i = 0; i < 1000 && busy; i++) begin
            ref_tick = 1;
            @(negedge clk);
        end
        ref_tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_gate_lengths();
        t_close_edge();
        t_busy_start();
        t_readout();
        t_shift_idle();
        t_done_hold();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule